// File: doc/BRIEF.md
# GPIO Port Data Register Bank

This block holds the data side of a 32-pin general-purpose I/O port. It sits behind a plain 32-bit memory-mapped register bus. The bus has a byte address, a write strobe with write data, and a read strobe whose data comes back one cycle later.

Inside, the block keeps an output data latch and a per-pin direction mask. It drives both straight onto the pad output and output-enable vectors. Three write-only aliases let software raise, lower or flip any group of output bits with one write, so no read-modify-write sequence is needed. Pin levels pass through a two-stage synchronizer and can then be read from an input register.

Pad multiplexing, pull control, interrupt detection and filtering all live in other blocks.

Top module: `gpio_data_bank`

## Requirements
- R1: After synchronous reset, `pin_out`, `pin_oe` and `bus_rdata` are all 0, so every pin starts as an input.
- R2: A write to byte address 0x00 loads the output latch with `bus_wdata`. `pin_out` shows the new value from the clock edge that takes the write. A read of 0x00 returns the latch.
- R3: A write to 0x04 forces to 1 every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R4: A write to 0x08 forces to 0 every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R5: A write to 0x0C inverts every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R6: A read of 0x10 returns `pin_in` delayed by two clock edges. A level applied just before edge k is first returned by a read strobed in the cycle after edge k+1.
- R7: Address 0x14 is a read/write direction mask, and `pin_oe` equals it. A bit value of 1 makes that pin an output and 0 makes it an input.
- R8: Reads of 0x04, 0x08, 0x0C return 0. So do reads of any address above 0x14 and any address whose two low bits are not 00.
- R9: Read data appears on `bus_rdata` at the clock edge that samples `bus_rd`. `bus_rdata` is 0 after any edge where `bus_rd` was low.
- R10: Writes to 0x10, to unmapped addresses, or to misaligned addresses change neither the output latch nor the direction mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Output latch value to pads |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The hardest case to reach from the ports is the exact latency of the input path. A value on `pin_in` must stay invisible to the first two back-to-back reads and appear on the third. The bench therefore changes `pin_in` in the same cycle that it issues a read, keeps the read strobe asserted for three cycles, and expects old, old, new. The atomic aliases are driven over a sequence of arithmetically generated masks on top of a running latch value, so set, clear and toggle each meet bits that are already 1 and bits that are already 0. Every word address above the map is then swept for both reads and writes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // word indices (byte address >> 2) of the mapped registers
  localparam int unsigned WI_OUT = 0;
  localparam int unsigned WI_SET = 1;
  localparam int unsigned WI_CLR = 2;
  localparam int unsigned WI_TOG = 3;
  localparam int unsigned WI_IN  = 4;
  localparam int unsigned WI_DIR = 5;

  typedef struct packed {
    logic dout;
    logic dset;
    logic dclr;
    logic dtog;
    logic din;
    logic ddir;
  } reg_sel_t;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output reg_sel_t      wsel,
  output reg_sel_t      rsel
);
  localparam int WW = AW - 2;

  logic [WW-1:0] widx;
  logic          aligned;
  reg_sel_t      hit;

  assign widx    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    hit      = '0;
    hit.dout = aligned && (widx == WW'(WI_OUT));
    hit.dset = aligned && (widx == WW'(WI_SET));
    hit.dclr = aligned && (widx == WW'(WI_CLR));
    hit.dtog = aligned && (widx == WW'(WI_TOG));
    hit.din  = aligned && (widx == WW'(WI_IN));
    hit.ddir = aligned && (widx == WW'(WI_DIR));
  end

  assign wsel = wr ? hit : '0;
  assign rsel = rd ? hit : '0;

  always_comb begin
    a_r8_sel_onehot: assert ($onehot0(hit));
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_sel_t         wsel,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wsel.dout)      out_q <= wdata;
      else if (wsel.dset) out_q <= out_q | wdata;
      else if (wsel.dclr) out_q <= out_q & ~wdata;
      else if (wsel.dtog) out_q <= out_q ^ wdata;
      if (wsel.ddir) dir_q <= wdata;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_q == '0 && dir_q == '0));
  a_r2_plain_load: assert property (@(posedge clk) disable iff (rst)
    wsel.dout |=> out_q == $past(wdata));
  a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
    wsel.dset |=> ((out_q & $past(wdata)) == $past(wdata))
                  && ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
    wsel.dclr |=> ((out_q & $past(wdata)) == '0)
                  && ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
  a_r5_toggle_bits: assert property (@(posedge clk) disable iff (rst)
    wsel.dtog |=> (out_q ^ $past(out_q)) == $past(wdata));
  a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(wsel.dout || wsel.dset || wsel.dclr || wsel.dtog) |=> $stable(out_q));
  a_r7_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !wsel.ddir |=> $stable(dir_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_sync
);
  logic [NPINS-1:0] stg [STAGES];

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[k] <= '0;
          else     stg[k] <= stg[k-1];
        end
      end
    end
  endgenerate

  assign pin_sync = stg[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] warm;
      always_ff @(posedge clk) begin
        if (rst)            warm <= '0;
        else if (warm != 2) warm <= warm + 2'd1;
      end
      a_r6_two_edge_delay: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> pin_sync == $past(pin_in, 2));
    end
  endgenerate
endmodule

// File: rtl/gpio_data_bank.sv
module gpio_data_bank
  import gpio_bank_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_rd,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  reg_sel_t         wsel;
  reg_sel_t         rsel;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] in_q;
  logic [NPINS-1:0] rd_mux;

  gpio_reg_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .wsel (wsel),
    .rsel (rsel)
  );

  gpio_out_latch #(.NPINS(NPINS)) u_lat (
    .clk   (clk),
    .rst   (rst),
    .wsel  (wsel),
    .wdata (bus_wdata),
    .out_q (out_q),
    .dir_q (dir_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .pin_sync (in_q)
  );

  // set/clear/toggle aliases and unmapped words contribute nothing
  always_comb begin
    rd_mux = '0;
    if (rsel.dout) rd_mux = rd_mux | out_q;
    if (rsel.din)  rd_mux = rd_mux | in_q;
    if (rsel.ddir) rd_mux = rd_mux | dir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
  a_r8_alias_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (rsel.dset || rsel.dclr || rsel.dtog)) |=> bus_rdata == '0);
  a_r7_oe_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && rsel.ddir) |=> bus_rdata == $past(pin_oe));
endmodule

// File: tb/sim_gpio_data_bank.sv
module sim_gpio_data_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int total = 0;
  int bad = 0;
  logic [31:0] e_out = '0;
  logic [31:0] e_dir = '0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  gpio_data_bank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_state(input string req);
    chk(req, pin_out, e_out);
    chk(req, pin_oe, e_dir);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out", pin_out, 32'h0);
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle", bus_rdata, 32'h0);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] v, m;
      v = (i * 32'h9E3779B9) ^ (32'h1 << i);
      m = (i * 32'h7F4A7C15) + 32'h0F0F_0011;
      // R2 plain load
      wr(8'h00, v); e_out = v;
      chk("R2 pin_out", pin_out, e_out);
      rd(8'h00, rv); chk("R2 readback", rv, e_out);
      // R3 set
      wr(8'h04, m); e_out = e_out | m;
      chk("R3 set", pin_out, e_out);
      // R4 clear
      wr(8'h08, m ^ v); e_out = e_out & ~(m ^ v);
      chk("R4 clear", pin_out, e_out);
      // R5 toggle
      wr(8'h0C, ~m); e_out = e_out ^ ~m;
      chk("R5 toggle", pin_out, e_out);
      // R7 direction
      wr(8'h14, v ^ m); e_dir = v ^ m;
      chk("R7 pin_oe", pin_oe, e_dir);
      rd(8'h14, rv); chk("R7 readback", rv, e_dir);
      // R8 aliases read zero
      rd(8'h04, rv); chk("R8 set alias", rv, 32'h0);
      rd(8'h08, rv); chk("R8 clr alias", rv, 32'h0);
      rd(8'h0C, rv); chk("R8 tog alias", rv, 32'h0);
      @(negedge clk);
      chk("R9 after read", bus_rdata, 32'h0);
    end

    // R6 latency: change pin_in while reading back-to-back
    for (int j = 0; j < 8; j++) begin
      logic [31:0] old_v, new_v;
      old_v = pin_in;
      new_v = (j * 32'h3C6EF372) ^ 32'hA5A5_5A5A;
      @(negedge clk);
      pin_in = new_v; bus_addr = 8'h10; bus_rd = 1'b1;
      @(negedge clk); chk("R6 edge1 old", bus_rdata, old_v);
      @(negedge clk); chk("R6 edge2 old", bus_rdata, old_v);
      @(negedge clk); chk("R6 edge3 new", bus_rdata, new_v);
      bus_rd = 1'b0;
      // R10 write to input register ignored
      wr(8'h10, ~new_v);
      check_state("R10 input write");
      rd(8'h10, rv); chk("R6 hold", rv, new_v);
    end

    // R8/R10 sweep of unmapped and misaligned addresses
    for (int a = 8'h15; a < 256; a++) begin
      if (a[1:0] == 2'b00 && a <= 8'h14) continue;
      wr(a[7:0], 32'hFFFF_FFFF ^ a);
      check_state("R10 unmapped write");
      rd(a[7:0], rv); chk("R8 unmapped read", rv, 32'h0);
    end
    for (int a = 1; a < 8'h14; a++) begin
      if (a[1:0] == 2'b00) continue;
      wr(a[7:0], 32'h5555_AAAA);
      check_state("R10 misaligned write");
      rd(a[7:0], rv); chk("R8 misaligned read", rv, 32'h0);
    end

    // R1 reset again after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    e_out = '0; e_dir = '0;
    check_state("R1 re-reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule